// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block steps a sigma-delta converter through its calibration modes. Software writes a two-bit mode code. A non-zero code starts a calibration. The sequencer then runs a zero-scale phase, a full-scale phase, or both. Each phase lasts a fixed number of output-rate periods, and the block counts those periods from a one-cycle conversion tick supplied by the filter.

The block reports completion in two ways. When calibration ends, the readable mode bits drop back to 00. At that point the offset or gain coefficient has been captured, but no new sample exists yet. The sequencer then runs one normal conversion and waits a fixed scaling delay in master-clock cycles. Only after that does it pull the active-low data-ready output low, which tells the reader that a valid post-calibration sample is in the data register.

A non-zero code written while a sequence is running abandons that sequence and starts the new one from its first phase. The scaling delay is the parameter `PIPE_CYCLES`, at least 1 and at most 2000.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released with no command, `phase` is 0 (idle), `mode_bits` is 00, `drdy_n` is 1, and both strobes are 0.
- R2: A write of code 01 (self), 10 (system zero-scale) or 11 (system full-scale) is accepted at the sampling edge. From the next cycle, `mode_bits` reads the code and `drdy_n` is 1. `phase` becomes 2 for code 11 and 1 otherwise.
- R3: In self-calibration, the zero-scale phase ends on the 3rd tick and pulses `offset_load` for one cycle. The full-scale phase ends on the 6th tick and pulses `gain_load` for one cycle. `mode_bits` returns to 00 on the 6th tick.
- R4: In system calibration, the single phase ends on the 3rd tick and `mode_bits` returns to 00. Code 10 pulses `offset_load` and code 11 pulses `gain_load`.
- R5: The normal conversion ends on the 9th tick (self) or the 4th tick (system), and the block then enters phase 4. `drdy_n` falls exactly `PIPE_CYCLES` clock edges after the edge that took the last tick.
- R6: Between the clearing of `mode_bits` and the fall of `drdy_n`, `drdy_n` stays 1 and `mode_bits` stays 00.
- R7: A non-zero write during any non-idle phase restarts the sequence. The new mode's tick counts begin from zero.
- R8: A write of code 00 has no effect on `phase`, `mode_bits` or `drdy_n`.
- R9: Ticks during idle or during the scaling delay are ignored. Once low, `drdy_n` stays low until the next accepted command.
- R10: `phase` encodes 0 idle, 1 zero-scale, 2 full-scale, 3 conversion and 4 scaling delay.
- R11: A tick on the same cycle as an accepted write is not counted toward the new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | One-cycle write strobe for the mode code |
| mode_in | input | 2 | Mode code written with `mode_wr` |
| conv_tick | input | 1 | One-cycle pulse per output-rate period |
| phase | output | 3 | Current sequence phase |
| offset_load | output | 1 | One-cycle strobe: offset coefficient captured |
| gain_load | output | 1 | One-cycle strobe: gain coefficient captured |
| mode_bits | output | 2 | Readable mode bits |
| drdy_n | output | 1 | Active-low data ready |

## Verification
The properties assume that `conv_tick` and `mode_wr` are single-cycle pulses sampled on the rising clock edge. They also assume that the tick source keeps running during calibration, since no phase ends without ticks. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. It varies the spacing between ticks from back-to-back to several idle cycles, and it places writes beside ticks, between ticks, and during the scaling delay.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ZS   = 3'd1,
    PH_FS   = 3'd2,
    PH_CONV = 3'd3,
    PH_PIPE = 3'd4
  } cal_phase_e;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_SELF   = 2'b01;
  localparam logic [1:0] MODE_SYS_ZS = 2'b10;
  localparam logic [1:0] MODE_SYS_FS = 2'b11;

  // first phase entered for an accepted calibration code
  function automatic cal_phase_e entry_phase(input logic [1:0] code);
    return (code == MODE_SYS_FS) ? PH_FS : PH_ZS;
  endfunction

  // number of output-rate ticks that close a phase
  function automatic int unsigned phase_len(input cal_phase_e ph, input logic self_cal,
                                            input int unsigned zs_n, input int unsigned fs_n,
                                            input int unsigned sys_n, input int unsigned cself_n,
                                            input int unsigned csys_n);
    case (ph)
      PH_ZS:   return self_cal ? zs_n : sys_n;
      PH_FS:   return self_cal ? fs_n : sys_n;
      PH_CONV: return self_cal ? cself_n : csys_n;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/cal_tick_counter.sv
module cal_tick_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = tick && !clr && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clr || done)   cnt <= '0;
    else if (tick)          cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cal_pipe_timer.sv
module cal_pipe_timer #(
  parameter int CYCLES = 16,
  localparam int W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [W-1:0] cnt;

  assign expire = run && (cnt == W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int ZS_TICKS        = 3,
  parameter int FS_TICKS        = 3,
  parameter int SYS_TICKS       = 3,
  parameter int SELF_CONV_TICKS = 3,
  parameter int SYS_CONV_TICKS  = 1,
  parameter int PIPE_CYCLES     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_in,
  input  logic       conv_tick,
  output logic [2:0] phase,
  output logic       offset_load,
  output logic       gain_load,
  output logic [1:0] mode_bits,
  output logic       drdy_n
);
  localparam int TICK_W = $clog2(ZS_TICKS + FS_TICKS + SYS_TICKS
                                 + SELF_CONV_TICKS + SYS_CONV_TICKS + 1);

  cal_phase_e        state;
  logic              self_q;
  logic [TICK_W-1:0] limit;

  // named internal events, visible to the bound checker
  logic start_cmd;
  logic tick_done;
  logic pipe_expire;
  logic tick_clr;

  assign start_cmd = mode_wr && (mode_in != MODE_NORMAL);
  assign tick_clr  = start_cmd ||
                     !(state == PH_ZS || state == PH_FS || state == PH_CONV);
  assign phase     = state;

  always_comb begin
    limit = TICK_W'(phase_len(state, self_q, ZS_TICKS, FS_TICKS, SYS_TICKS,
                              SELF_CONV_TICKS, SYS_CONV_TICKS));
  end

  cal_tick_counter #(.W(TICK_W)) u_ticks (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tick_clr),
    .tick  (conv_tick),
    .limit (limit),
    .done  (tick_done)
  );

  cal_pipe_timer #(.CYCLES(PIPE_CYCLES)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == PH_PIPE && !start_cmd),
    .expire (pipe_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= PH_IDLE;
      self_q      <= 1'b0;
      mode_bits   <= MODE_NORMAL;
      drdy_n      <= 1'b1;
      offset_load <= 1'b0;
      gain_load   <= 1'b0;
    end else begin
      offset_load <= 1'b0;
      gain_load   <= 1'b0;
      if (start_cmd) begin
        state     <= entry_phase(mode_in);
        self_q    <= (mode_in == MODE_SELF);
        mode_bits <= mode_in;
        drdy_n    <= 1'b1;
      end else begin
        case (state)
          PH_ZS: if (tick_done) begin
            offset_load <= 1'b1;
            if (self_q) state <= PH_FS;
            else begin
              state     <= PH_CONV;
              mode_bits <= MODE_NORMAL;
            end
          end
          PH_FS: if (tick_done) begin
            gain_load <= 1'b1;
            state     <= PH_CONV;
            mode_bits <= MODE_NORMAL;
          end
          PH_CONV: if (tick_done) state <= PH_PIPE;
          PH_PIPE: if (pipe_expire) begin
            state  <= PH_IDLE;
            drdy_n <= 1'b0;
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
  import cal_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [1:0] mode_in,
  input logic       conv_tick,
  input logic [2:0] phase,
  input logic       offset_load,
  input logic       gain_load,
  input logic [1:0] mode_bits,
  input logic       drdy_n,
  input logic       start_cmd,
  input logic       tick_done,
  input logic       pipe_expire
);
  p_cmd_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (mode_bits == $past(mode_in) && drdy_n &&
                   (phase == PH_ZS || phase == PH_FS)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(offset_load && gain_load));

  p_offset_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offset_load |-> $past(phase) == PH_ZS);

  p_gain_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_load |-> $past(phase) == PH_FS);

  p_after_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV || phase == PH_PIPE) |-> (mode_bits == MODE_NORMAL && drdy_n));

  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> drdy_n);

  p_ready_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> ($past(phase) == PH_PIPE && $past(pipe_expire)));

  p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == MODE_NORMAL && !tick_done && !pipe_expire)
      |=> ($stable(mode_bits) && $stable(phase) && $stable(drdy_n)));

  p_idle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && conv_tick && !mode_wr) |=> $stable(drdy_n));

  p_phase_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);
endmodule

bind cal_seq_ctrl cal_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_wr     (mode_wr),
  .mode_in     (mode_in),
  .conv_tick   (conv_tick),
  .phase       (phase),
  .offset_load (offset_load),
  .gain_load   (gain_load),
  .mode_bits   (mode_bits),
  .drdy_n      (drdy_n),
  .start_cmd   (start_cmd),
  .tick_done   (tick_done),
  .pipe_expire (pipe_expire)
);

// File: tb/tb_cal_seq_ctrl.sv
module tb_cal_seq_ctrl;
  localparam int PIPE = 20;
  localparam logic [2:0] S_IDLE = 3'd0, S_ZS = 3'd1, S_FS = 3'd2, S_CONV = 3'd3, S_PIPE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic conv_tick = 1'b0;
  logic [2:0] phase;
  logic offset_load, gain_load, drdy_n;
  logic [1:0] mode_bits;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int         at;
    string      tag;
    logic [2:0] ph;
    logic [1:0] mb;
    logic       dr;
    logic       off;
    logic       gn;
  } exp_t;
  exp_t sb[$];

  cal_seq_ctrl #(.PIPE_CYCLES(PIPE)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .conv_tick(conv_tick), .phase(phase), .offset_load(offset_load),
    .gain_load(gain_load), .mode_bits(mode_bits), .drdy_n(drdy_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations due at this edge and compare
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        total++;
        if (phase !== sb[i].ph || mode_bits !== sb[i].mb || drdy_n !== sb[i].dr ||
            offset_load !== sb[i].off || gain_load !== sb[i].gn) begin
          fails++;
          $display("FAIL %s edge %0d: actual ph=%0d mb=%b dr=%b off=%b gn=%b expected ph=%0d mb=%b dr=%b off=%b gn=%b",
                   sb[i].tag, cyc, phase, mode_bits, drdy_n, offset_load, gain_load,
                   sb[i].ph, sb[i].mb, sb[i].dr, sb[i].off, sb[i].gn);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int at, string tag, logic [2:0] ph, logic [1:0] mb,
                           logic dr, logic off, logic gn);
    exp_t e;
    e.at = at; e.tag = tag; e.ph = ph; e.mb = mb; e.dr = dr; e.off = off; e.gn = gn;
    sb.push_back(e);
  endtask

  task automatic step(logic w, logic [1:0] c, logic t);
    mode_wr = w; mode_in = c; conv_tick = t;
    @(negedge clk);
    mode_wr = 1'b0; conv_tick = 1'b0;
  endtask

  task automatic write_cmd(logic [1:0] code, logic with_tick);
    expect_at(cyc + 1, "R2 accept", (code == 2'b11) ? S_FS : S_ZS, code, 1'b1, 1'b0, 1'b0);
    step(1'b1, code, with_tick);  // R11: a simultaneous tick must not count
  endtask

  // full calibration; expectations derived from the requirement tick counts
  task automatic run_cal(logic [1:0] code, int gap, logic with_tick, logic zero_mid);
    bit self_m = (code == 2'b01);
    int last = self_m ? 9 : 4;
    logic [2:0] first = (code == 2'b11) ? S_FS : S_ZS;
    logic [2:0] eph; logic [1:0] emb; logic eoff, egn;
    int e_last;
    write_cmd(code, with_tick);
    for (int i = 1; i <= last; i++) begin
      eoff = 1'b0; egn = 1'b0;
      if (self_m) begin
        if (i < 3)      begin eph = S_ZS; emb = 2'b01; end
        else if (i == 3) begin eph = S_FS; emb = 2'b01; eoff = 1'b1; end
        else if (i < 6) begin eph = S_FS; emb = 2'b01; end
        else if (i == 6) begin eph = S_CONV; emb = 2'b00; egn = 1'b1; end
        else if (i < 9) begin eph = S_CONV; emb = 2'b00; end
        else            begin eph = S_PIPE; emb = 2'b00; end
      end else begin
        if (i < 3)       begin eph = first; emb = code; end
        else if (i == 3) begin eph = S_CONV; emb = 2'b00;
                               eoff = (code == 2'b10); egn = (code == 2'b11); end
        else             begin eph = S_PIPE; emb = 2'b00; end
      end
      expect_at(cyc + 1, self_m ? "R3 self tick" : "R4 system tick", eph, emb, 1'b1, eoff, egn);
      if (gap > 0 && i < last)
        expect_at(cyc + 2, "R6 strobe width", eph, emb, 1'b1, 1'b0, 1'b0);
      step(1'b0, 2'b00, 1'b1);
      e_last = cyc;
      if (zero_mid && i == 1) begin
        expect_at(cyc + 1, "R8 zero write mid-run", first, code, 1'b1, 1'b0, 1'b0);
        step(1'b1, 2'b00, 1'b0);
      end
      if (i < last) for (int g = 0; g < gap; g++) step(1'b0, 2'b00, 1'b0);
    end
    expect_at(e_last + PIPE - 1, "R5 still busy", S_PIPE, 2'b00, 1'b1, 1'b0, 1'b0);
    expect_at(e_last + PIPE, "R5 ready", S_IDLE, 2'b00, 1'b0, 1'b0, 1'b0);
    expect_at(e_last + PIPE + 6, "R9 ticks ignored", S_IDLE, 2'b00, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= PIPE + 7; k++) step(1'b0, 2'b00, (k % 4) == 0);
  endtask

  initial begin
    @(negedge clk);
    expect_at(cyc + 1, "R1 in reset", S_IDLE, 2'b00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    rst_n = 1'b1;
    expect_at(cyc + 2, "R1 after reset", S_IDLE, 2'b00, 1'b1, 1'b0, 1'b0);
    expect_at(cyc + 3, "R10 idle with tick", S_IDLE, 2'b00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b1);

    run_cal(2'b01, 2, 1'b0, 1'b1);
    run_cal(2'b10, 0, 1'b1, 1'b0);
    run_cal(2'b11, 1, 1'b0, 1'b1);

    // R7: restart a self-calibration midway through its full-scale phase
    write_cmd(2'b01, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      if (i == 3) expect_at(cyc + 1, "R7 partial offset", S_FS, 2'b01, 1'b1, 1'b1, 1'b0);
      step(1'b0, 2'b00, 1'b1);
      step(1'b0, 2'b00, 1'b0);
    end
    run_cal(2'b11, 1, 1'b0, 1'b0);

    // R8: zero write while idle and ready
    expect_at(cyc + 1, "R8 zero write idle", S_IDLE, 2'b00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);

    // R7: restart during the scaling delay with a system zero-scale run
    write_cmd(2'b01, 1'b0);
    for (int i = 1; i <= 9; i++) step(1'b0, 2'b00, 1'b1);
    expect_at(cyc + 3, "R7 in delay", S_PIPE, 2'b00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    run_cal(2'b10, 1, 1'b0, 1'b0);

    run_cal(2'b01, 0, 1'b0, 1'b0);

    step(1'b0, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0);
    if (sb.size() != 0) begin
      total++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual edge %0d expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule